// File: doc/BRIEF.md
# SDRAM Column Command Decoder and Burst Sequencer

This block sits on the device side of a synchronous DRAM. On every rising clock edge it samples the three active-low command strobes, the bank select and the address bus. It recognises column reads and writes, each with or without automatic precharge, and it recognises precharge. For each accepted access it steps through the burst one column per clock. It reports every beat as a registered column address and bank, together with a write-beat or read-beat flag. The flags drive the storage array that sits outside the block. Write data presented on the same edge as the Write command belongs to the first beat.

The burst length comes from a static three-bit configuration input. The column order is sequential and wraps inside the aligned block of the burst length. In full-page mode the order runs on without end and wraps from the last column to column 0. A later Write or Read restarts the sequencer at once from its own column. A Precharge ends the running burst. An access with automatic precharge (except in full-page mode) has three effects. It raises a one-cycle precharge request after its last beat. It holds a busy flag high for TRP plus burst-length clock edges, and every command during that window is ignored.

Top module: `sdram_col_burst`

## Requirements
- R1: Commands are decoded from (rowSelN, colSelN, wrSelN). Read is (1,0,1), Write is (1,0,0), Precharge is (0,1,0) and NOP is (1,1,1). For Read and Write, address bit 10 set requests automatic precharge, and address bits 8..0 give the start column.
- R2: An accepted Write sampled at edge T gives wrBeat=1 with colAddr equal to the start column and bankAddr equal to the sampled bank in the cycle after T. Beat k of the burst is reported in the cycle after edge T+k.
- R3: burstCfg codes 0, 1, 2 and 3 select lengths 1, 2, 4 and 8. The column address increments and wraps inside the block of that length aligned to a multiple of the length. For example, length 4 starting at column 5 gives 5, 6, 7, 4.
- R4: burstCfg code 7 selects full page. The burst runs until it is terminated, and the column after 511 is 0.
- R5: A Read or Write with automatic precharge in full-page mode performs only the access. It raises neither precReq nor busy.
- R6: An access with automatic precharge and a finite length L that is accepted at edge T drives precReq high for exactly the one cycle after edge T+L, with bankAddr unchanged.
- R7: After an auto-precharge access of length L accepted at edge T, busy is high and all commands sampled at edges T+1 through T+TRP+L are ignored. The command at edge T+TRP+L+1 is accepted.
- R8: A Write sampled during a running write burst restarts the burst from its own column and length in the following cycle.
- R9: A Read sampled during a write burst ends the write beats. From the next cycle wrBeat stays low and rdBeat reports the read burst.
- R10: An accepted Precharge drives wrBeat and rdBeat low from the next cycle, including in full-page mode.
- R11: NOP and all other command codes leave a running burst advancing unchanged.
- R12: While rstN is low, all outputs are 0.
- R13: burstCfg codes 4, 5 and 6 are treated as length 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowSelN | input | 1 | Row strobe, active low |
| colSelN | input | 1 | Column strobe, active low |
| wrSelN | input | 1 | Write strobe, active low |
| bankSel | input | BANK_W | Bank select sampled with the command |
| addrIn | input | ADDR_W | Address bus: column in low bits, auto-precharge flag in bit AP_BIT |
| burstCfg | input | 3 | Static burst-length code |
| colAddr | output | COL_W | Column of the current beat |
| bankAddr | output | BANK_W | Bank of the current burst |
| wrBeat | output | 1 | Current beat is a write |
| rdBeat | output | 1 | Current beat is a read |
| precReq | output | 1 | One-cycle automatic precharge request |
| busy | output | 1 | Auto-precharge hold-off window, commands ignored |

## Verification
The bench targets the column wrap inside an aligned block that does not start at its base. A design that carries into the upper bits would leave the block and emit 8 instead of 4. It runs a full-page burst across column 511, where a sequencer that stopped or saturated would show up at once. The bench probes both edges of the busy window with Writes: a counter off by one would either accept the first blocked Write or lose the first legal one. It also sends interrupting Writes, Reads and Precharges, a full-page access with automatic precharge, and non-access commands in the middle of bursts. A leaked write beat, a spurious precReq, or a burst that stalls on NOP would each differ from the reference model within one cycle.

// File: rtl/sdfe_pkg.sv
package sdfe_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_READ,
    CMD_WRITE,
    CMD_PRE,
    CMD_OTHER
  } cmdKind_t;

  // Strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic load;     // start a new burst from the sampled column
    logic advance;  // step to the next column of the burst
    logic halt;     // no beat in the coming cycle
    logic isWrite;  // direction of a loaded burst
  } beatStrobe_t;

  localparam logic [2:0] CFG_FULL = 3'b111;

endpackage

// File: rtl/sdfe_decode.sv
module sdfe_decode
  import sdfe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  logic              rowSelN,
  input  logic              colSelN,
  input  logic              wrSelN,
  input  logic [ADDR_W-1:0] addrIn,
  output cmdKind_t          cmdKind,
  output logic              apFlag,
  output logic [COL_W-1:0]  colStart
);

  logic [2:0] strobeVec;
  logic unusedAddr;

  assign strobeVec = {rowSelN, colSelN, wrSelN};
  assign apFlag    = addrIn[AP_BIT];
  assign colStart  = addrIn[COL_W-1:0];
  assign unusedAddr = ^addrIn;

  always_comb begin
    unique case (strobeVec)
      3'b111:  cmdKind = CMD_NOP;
      3'b101:  cmdKind = CMD_READ;
      3'b100:  cmdKind = CMD_WRITE;
      3'b010:  cmdKind = CMD_PRE;
      default: cmdKind = CMD_OTHER;
    endcase
  end

endmodule

// File: rtl/sdfe_ctrl.sv
module sdfe_ctrl
  import sdfe_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int TRP   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmdKind_t         cmdKind,
  input  logic             apFlag,
  input  logic [2:0]       burstCfg,
  output beatStrobe_t      strb,
  output logic [COL_W-1:0] stepMask,
  output logic             busy,
  output logic             precReq
);

  localparam int LEN_W  = COL_W + 1;
  localparam int PAGE   = 1 << COL_W;
  localparam int HOLD_W = $clog2(TRP + 8 + 1);

  logic [LEN_W-1:0]  lenCur;
  logic              fullCfg;
  logic [COL_W-1:0]  remQ;
  logic              fullQ;
  logic              apQ;
  logic [HOLD_W-1:0] holdQ;
  logic [COL_W-1:0]  maskQ;
  logic              precReqQ;
  logic              accept;
  logic              running;
  logic              isAccess;
  logic              preHit;

  always_comb begin
    unique case (burstCfg)
      3'b001:   lenCur = LEN_W'(2);
      3'b010:   lenCur = LEN_W'(4);
      3'b011:   lenCur = LEN_W'(8);
      CFG_FULL: lenCur = LEN_W'(PAGE);
      default:  lenCur = LEN_W'(1);
    endcase
  end

  assign fullCfg  = (burstCfg == CFG_FULL);
  assign accept   = (holdQ == '0);
  assign running  = fullQ || (remQ != '0);
  assign isAccess = (cmdKind == CMD_READ) || (cmdKind == CMD_WRITE);
  assign preHit   = accept && (cmdKind == CMD_PRE);

  always_comb begin
    strb         = '0;
    strb.isWrite = (cmdKind == CMD_WRITE);
    if (accept && isAccess)  strb.load    = 1'b1;
    else if (preHit)         strb.halt    = 1'b1;
    else if (running)        strb.advance = 1'b1;
    else                     strb.halt    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ     <= '0;
      fullQ    <= 1'b0;
      apQ      <= 1'b0;
      holdQ    <= '0;
      maskQ    <= '0;
      precReqQ <= 1'b0;
    end else begin
      precReqQ <= 1'b0;
      if (holdQ != '0) holdQ <= holdQ - 1'b1;
      if (strb.load) begin
        remQ  <= COL_W'(lenCur - 1'b1);
        maskQ <= COL_W'(lenCur - 1'b1);
        fullQ <= fullCfg;
        apQ   <= apFlag && !fullCfg;
        if (apFlag && !fullCfg)
          holdQ <= HOLD_W'(TRP) + HOLD_W'(lenCur);
      end else if (preHit) begin
        remQ  <= '0;
        fullQ <= 1'b0;
      end else if (strb.advance) begin
        if (!fullQ) remQ <= remQ - 1'b1;
      end else if (apQ) begin
        precReqQ <= 1'b1;
        apQ      <= 1'b0;
      end
    end
  end

  assign stepMask = maskQ;
  assign busy     = (holdQ != '0);
  assign precReq  = precReqQ;

  // R7: no burst may start inside the hold-off window
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ != '0) |-> !strb.load);

  // R5: a full-page burst never carries a pending precharge
  p_full_no_ap_r5: assert property (@(posedge clk) disable iff (!rstN)
    fullQ |-> !apQ);

  // R6: the precharge request lasts a single cycle
  p_prec_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    precReqQ |=> !precReqQ);

  // R11: a NOP keeps a running burst stepping
  p_nop_keeps_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == CMD_NOP && running) |-> strb.advance);

endmodule

// File: rtl/sdfe_dp.sv
module sdfe_dp
  import sdfe_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  beatStrobe_t       strb,
  input  logic [COL_W-1:0]  stepMask,
  input  logic [COL_W-1:0]  colStart,
  input  logic [BANK_W-1:0] bankSel,
  output logic [COL_W-1:0]  colAddr,
  output logic [BANK_W-1:0] bankAddr,
  output logic              wrBeat,
  output logic              rdBeat
);

  logic [COL_W-1:0]  colQ;
  logic [BANK_W-1:0] bankQ;
  logic              wrQ;
  logic              rdQ;
  logic [COL_W-1:0]  colInc;
  logic [COL_W-1:0]  colNext;

  assign colInc  = colQ + 1'b1;
  assign colNext = (colQ & ~stepMask) | (colInc & stepMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ  <= '0;
      bankQ <= '0;
      wrQ   <= 1'b0;
      rdQ   <= 1'b0;
    end else if (strb.load) begin
      colQ  <= colStart;
      bankQ <= bankSel;
      wrQ   <= strb.isWrite;
      rdQ   <= !strb.isWrite;
    end else if (strb.advance) begin
      colQ <= colNext;
    end else if (strb.halt) begin
      wrQ <= 1'b0;
      rdQ <= 1'b0;
    end
  end

  assign colAddr  = colQ;
  assign bankAddr = bankQ;
  assign wrBeat   = wrQ;
  assign rdBeat   = rdQ;

  // R9: a loaded read leaves no write beat behind
  p_read_stops_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.isWrite) |=> (!wrBeat && rdBeat));

  // R10: a halt leaves no beat in the next cycle
  p_halt_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.halt |=> (!wrBeat && !rdBeat));

  // R3: stepping never leaves the aligned block
  p_step_in_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> ((colQ & ~$past(stepMask)) == ($past(colQ) & ~$past(stepMask))));

endmodule

// File: rtl/sdram_col_burst.sv
module sdram_col_burst
  import sdfe_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int TRP    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowSelN,
  input  logic              colSelN,
  input  logic              wrSelN,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        burstCfg,
  output logic [COL_W-1:0]  colAddr,
  output logic [BANK_W-1:0] bankAddr,
  output logic              wrBeat,
  output logic              rdBeat,
  output logic              precReq,
  output logic              busy
);

  cmdKind_t         cmdKind;
  logic             apFlag;
  logic [COL_W-1:0] colStart;
  logic [COL_W-1:0] stepMask;
  beatStrobe_t      strb;

  sdfe_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) uDecode (
    .rowSelN (rowSelN),
    .colSelN (colSelN),
    .wrSelN  (wrSelN),
    .addrIn  (addrIn),
    .cmdKind (cmdKind),
    .apFlag  (apFlag),
    .colStart(colStart)
  );

  sdfe_ctrl #(.COL_W(COL_W), .TRP(TRP)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdKind (cmdKind),
    .apFlag  (apFlag),
    .burstCfg(burstCfg),
    .strb    (strb),
    .stepMask(stepMask),
    .busy    (busy),
    .precReq (precReq)
  );

  sdfe_dp #(.COL_W(COL_W), .BANK_W(BANK_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .stepMask(stepMask),
    .colStart(colStart),
    .bankSel (bankSel),
    .colAddr (colAddr),
    .bankAddr(bankAddr),
    .wrBeat  (wrBeat),
    .rdBeat  (rdBeat)
  );

  // R6: a precharge request always follows a beat
  p_prec_after_beat_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(precReq) |-> $past(wrBeat || rdBeat));

  // R12: reset clears every output
  p_reset_quiet_r12: assert property (@(posedge clk)
    !rstN |=> (!wrBeat && !rdBeat && !precReq && !busy) || !rstN);

endmodule

// File: tb/tb_sdram_col_burst.sv
module tb_sdram_col_burst;

  localparam int TRP = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rowSelN = 1'b1, colSelN = 1'b1, wrSelN = 1'b1;
  logic [1:0] bankSel = '0;
  logic [10:0] addrIn = '0;
  logic [2:0] burstCfg = 3'd0;
  logic [8:0] colAddr;
  logic [1:0] bankAddr;
  logic       wrBeat, rdBeat, precReq, busy;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string curReq = "R12";

  // reference model state
  int mCol = 0, mBank = 0, mWr = 0, mRd = 0, mPrec = 0, mBusy = 0;
  int mRem = 0, mFull = 0, mAp = 0, mHold = 0;
  int mStart = 0, mBase = 0, mLen = 1, mK = 0;

  always #5 clk = ~clk;

  sdram_col_burst #(.TRP(TRP)) dut (
    .clk(clk), .rstN(rstN), .rowSelN(rowSelN), .colSelN(colSelN), .wrSelN(wrSelN),
    .bankSel(bankSel), .addrIn(addrIn), .burstCfg(burstCfg),
    .colAddr(colAddr), .bankAddr(bankAddr), .wrBeat(wrBeat), .rdBeat(rdBeat),
    .precReq(precReq), .busy(busy)
  );

  function automatic int lenOf(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 512;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", curReq, name, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int nextHold;
    bit isRd, isWr, isPre, ok;
    isRd  = ({rowSelN, colSelN, wrSelN} == 3'b101);
    isWr  = ({rowSelN, colSelN, wrSelN} == 3'b100);
    isPre = ({rowSelN, colSelN, wrSelN} == 3'b010);
    ok    = (mHold == 0);
    nextHold = (mHold > 0) ? mHold - 1 : 0;
    mPrec = 0;
    if (!rstN) begin
      mCol = 0; mBank = 0; mWr = 0; mRd = 0; mRem = 0; mFull = 0; mAp = 0;
      nextHold = 0;
    end else if (ok && (isRd || isWr)) begin
      mLen   = lenOf(burstCfg);
      mFull  = (burstCfg == 3'd7);
      mStart = addrIn % 512;
      mBase  = mStart - (mStart % mLen);
      mK     = 0;
      mCol   = mStart;
      mBank  = bankSel;
      mWr    = isWr;
      mRd    = isRd;
      mRem   = mLen - 1;
      mAp    = addrIn[10] && !mFull;
      if (mAp != 0) nextHold = TRP + mLen;
    end else if (ok && isPre) begin
      mWr = 0; mRd = 0; mRem = 0; mFull = 0;
    end else if (mFull != 0 || mRem > 0) begin
      mK++;
      mCol = mBase + ((mStart - mBase + mK) % mLen);
      if (mFull == 0) mRem--;
    end else begin
      mWr = 0; mRd = 0;
      if (mAp != 0) begin mPrec = 1; mAp = 0; end
    end
    mHold = nextHold;
    mBusy = (mHold != 0);
  endtask

  task automatic compareAll();
    chk("colAddr", colAddr, mCol);
    chk("bankAddr", bankAddr, mBank);
    chk("wrBeat", wrBeat, mWr);
    chk("rdBeat", rdBeat, mRd);
    chk("precReq", precReq, mPrec);
    chk("busy", busy, mBusy);
  endtask

  // one clock with the given strobes {row,col,wr}
  task automatic cyc(input logic [2:0] s, input int bank, input int addr);
    {rowSelN, colSelN, wrSelN} = s;
    bankSel = 2'(bank);
    addrIn  = 11'(addr);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) cyc(3'b111, 0, 0);
  endtask

  localparam logic [2:0] RD = 3'b101, WR = 3'b100, PRE = 3'b010, ACT = 3'b011;

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(3'b111, 0, 0);   // R12: outputs zero in reset
    curReq = "R12";
    chk("resetBeat", wrBeat | rdBeat, 0);
    rstN = 1'b1;

    curReq = "R2"; burstCfg = 3'd2;          // write length 4 from 5: 5,6,7,4 (R3)
    cyc(WR, 2, 5); nops(5);
    curReq = "R3"; burstCfg = 3'd3;          // read length 8 from 13 (R1)
    cyc(RD, 1, 13); nops(9);
    curReq = "R3"; burstCfg = 3'd1;
    cyc(RD, 3, 7); nops(3);
    burstCfg = 3'd0;
    cyc(WR, 0, 9); nops(2);
    curReq = "R13"; burstCfg = 3'd5;
    cyc(WR, 1, 100); nops(3);

    curReq = "R4"; burstCfg = 3'd7;          // full page across 511
    cyc(WR, 2, 508); nops(8);
    curReq = "R10"; cyc(PRE, 0, 0); nops(3);

    curReq = "R5";                            // AP ignored in full page
    cyc(RD, 1, 1024 + 3); nops(4);
    cyc(PRE, 0, 0); nops(2);

    curReq = "R6"; burstCfg = 3'd2;          // read AP length 4, busy window 6 edges
    cyc(RD, 3, 1024 + 10);
    curReq = "R7";
    cyc(WR, 0, 40);                           // edge T+1 blocked
    nops(4);
    cyc(WR, 0, 50);                           // edge T+6 blocked
    cyc(WR, 1, 60);                           // edge T+7 accepted
    nops(6);

    curReq = "R6"; burstCfg = 3'd1;
    cyc(WR, 2, 1024 + 33); nops(6);

    curReq = "R8"; burstCfg = 3'd3;
    cyc(WR, 0, 16); nops(2);
    cyc(WR, 1, 27); nops(9);

    curReq = "R9";
    cyc(WR, 2, 40); nops(1);
    cyc(RD, 2, 44); nops(9);

    curReq = "R11"; burstCfg = 3'd2;
    cyc(WR, 3, 21); cyc(ACT, 0, 0); cyc(3'b001, 0, 0); nops(3);

    curReq = "R10"; burstCfg = 3'd3;
    cyc(RD, 0, 2); nops(2); cyc(PRE, 0, 0); nops(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule